// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between a free-running source clock and the loads that use it. It produces a gated true clock and a complement clock. The complement comes as a data value with its own output-enable, so that a pad can float it. An active-low stop request arrives with no timing relation to the source clock. It passes through a synchronizer into the clock domain. A small state machine then decides, on rising source edges, whether the clock is released or held.

The permission that gates the clock is captured on the falling source edge, while the source is low, before it reaches the AND gate. Each output high phase is therefore either whole or absent. On a stop, the true output keeps running for a few whole cycles, makes its last move downward and rests low, and the complement is floated. On a release, both outputs stay idle for a few whole cycles, and the first activity is a rising edge of the true output.

The state machine has four states. ST_RUN passes the clock. ST_DRAIN passes extra pulses after a stop is seen and is used only when DRAIN_CYC > 0. ST_PARKED holds the clock. ST_WAKE adds idle cycles before resuming and is used only when WAKE_CYC > 0. The transitions are named as follows. go_stop leaves ST_RUN on a synchronized stop, to ST_DRAIN or directly to ST_PARKED. drain_done goes from ST_DRAIN to ST_PARKED when the drain count is used up. go_wake leaves ST_PARKED on a synchronized release, to ST_WAKE or directly to ST_RUN. wake_done goes from ST_WAKE to ST_RUN. With the default parameters (two synchronizer stages, no drain, no wake), both the stop and the restart take three whole source cycles.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While reset is low, and after it, until a stop is synchronized: clk_out follows clk_src, clk_out_b_oe is 1, and the synchronizer holds the not-stopped level (1).
- R2: Let k be the first rising source edge that samples stop_req_n at 0, with the request then held low. The high pulses that start at edges k, k+1, ..., k+2+DRAIN_CYC are all present. No pulse follows them while the request stays low, so 3 + DRAIN_CYC pulses are counted from edge k.
- R3: clk_out is 0 throughout every low phase of clk_src. In every high phase, clk_out is either 1 for the whole phase or 0 for the whole phase. While stopped, it rests at 0.
- R4: Whenever clk_out_b_oe is 1, clk_out_b is the inverse of clk_out. clk_out_b_oe is 1 in exactly those high phases in which clk_out pulses. It changes only on falling source edges, so it goes low at the falling edge that ends the last pulse.
- R5: Let k be the first rising edge that samples stop_req_n at 1 after the clock has stopped. No pulse starts at edges k through k+2+WAKE_CYC. The next pulse starts at edge k+3+WAKE_CYC and begins with a rising edge.
- R6: A request that is sampled low by even one rising edge runs a complete stop-then-restart sequence. When the request is back high at the following edge, exactly 1 + WAKE_CYC pulses are missing, and the pulse pattern before and after the gap is unchanged.
- R7: A low pulse on stop_req_n that begins and ends between two rising source edges has no effect on any output.
- R8: DRAIN_CYC and WAKE_CYC lengthen the stop and the restart by exactly that many whole cycles. With both at 0, each latency sits within the one-to-three-cycle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Free-running source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req_n | input | 1 | Asynchronous stop request: 0 asks the clock to stop, 1 asks it to run |
| clk_out | output | 1 | Gated true clock |
| clk_out_b | output | 1 | Complement clock value, valid while clk_out_b_oe is 1 |
| clk_out_b_oe | output | 1 | Output-enable for the complement; 0 means the pad floats |

## Verification
A change on stop_req_n takes effect on clk_out at a fixed edge. It first shows at the pulse of rising edge k+3 (or k+3+DRAIN_CYC / k+3+WAKE_CYC), where k is the first edge that samples the change. The enable also changes at falling edge k+2 (plus the extra cycles), and it is seen first in the low phase of that cycle. The bench drives every input at 80 % of the period, so each edge samples one well-defined level. It samples each high phase at 10 % and 30 % and each low phase at 70 %. These values are compared against a behavioural queue model, updated at each rising edge, that predicts the next pulse and enable. Explicit pulse and gap counts after each stimulus check the latencies of R2, R5, R6 and R8 for the default instance and for one with extra drain and wake cycles.

// File: rtl/csc_pkg.sv
package csc_pkg;

    // Controller states.
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,  // clock passes
        ST_DRAIN  = 2'd1,  // stop seen, extra pulses still passing
        ST_PARKED = 2'd2,  // clock held low, complement floated
        ST_WAKE   = 2'd3   // release seen, extra idle cycles
    } csc_state_e;

    // Width of a down-counter that must hold values up to n-1.
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/csc_sync.sv
module csc_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    localparam int N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] chain;

    // Stage 0 takes the asynchronous input; each later stage takes the one before it.
    generate
        for (genvar s = 0; s < N; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RESET_VAL;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RESET_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[N-1];

endmodule

// File: rtl/csc_fsm.sv
module csc_fsm
    import csc_pkg::*;
#(
    parameter int DRAIN_CYC = 0,
    parameter int WAKE_CYC  = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_req,     // synchronized: 1 = run, 0 = stop
    output csc_state_e state,
    output logic       run_en       // permission for the next high phase
);

    localparam int MAXC        = (DRAIN_CYC > WAKE_CYC) ? DRAIN_CYC : WAKE_CYC;
    localparam int CW          = cnt_width(MAXC);
    localparam bit HAS_DRAIN   = (DRAIN_CYC > 0);
    localparam bit HAS_WAKE    = (WAKE_CYC > 0);
    localparam int DRAIN_LD_I  = HAS_DRAIN ? DRAIN_CYC - 1 : 0;
    localparam int WAKE_LD_I   = HAS_WAKE  ? WAKE_CYC  - 1 : 0;
    localparam logic [CW-1:0] DRAIN_LD = DRAIN_LD_I[CW-1:0];
    localparam logic [CW-1:0] WAKE_LD  = WAKE_LD_I[CW-1:0];

    csc_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // Next-state logic with named transitions.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_RUN: begin
                if (!run_req) begin                      // go_stop
                    if (HAS_DRAIN) begin
                        st_d  = ST_DRAIN;
                        cnt_d = DRAIN_LD;
                    end else begin
                        st_d  = ST_PARKED;
                    end
                end
            end
            ST_DRAIN: begin
                if (cnt_q == '0) st_d  = ST_PARKED;      // drain_done
                else             cnt_d = cnt_q - 1'b1;
            end
            ST_PARKED: begin
                if (run_req) begin                       // go_wake
                    if (HAS_WAKE) begin
                        st_d  = ST_WAKE;
                        cnt_d = WAKE_LD;
                    end else begin
                        st_d  = ST_RUN;
                    end
                end
            end
            ST_WAKE: begin
                if (cnt_q == '0) st_d  = ST_RUN;         // wake_done
                else             cnt_d = cnt_q - 1'b1;
            end
            default: st_d = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Outputs.
    always_comb begin
        unique case (st_q)
            ST_RUN, ST_DRAIN:    run_en = 1'b1;
            ST_PARKED, ST_WAKE:  run_en = 1'b0;
            default:             run_en = 1'b1;
        endcase
    end

    assign state = st_q;

endmodule

// File: rtl/csc_gate.sv
module csc_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    output logic clk_out,
    output logic clk_out_b,
    output logic out_en
);

    logic en_q;

    // Captured while clk is low, so en_q is steady through every high phase.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b1;
        else        en_q <= run_en;
    end

    assign clk_out   = clk & en_q;
    assign clk_out_b = ~clk_out;
    assign out_en    = en_q;

endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
    import csc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DRAIN_CYC   = 0,
    parameter int WAKE_CYC    = 0
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic stop_req_n,
    output logic clk_out,
    output logic clk_out_b,
    output logic clk_out_b_oe
);

    logic       sync_run;
    logic       run_en;
    csc_state_e fsm_state;

    csc_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk     (clk_src),
        .rst_n   (rst_n),
        .d_async (stop_req_n),
        .q_sync  (sync_run)
    );

    csc_fsm #(
        .DRAIN_CYC (DRAIN_CYC),
        .WAKE_CYC  (WAKE_CYC)
    ) u_fsm (
        .clk     (clk_src),
        .rst_n   (rst_n),
        .run_req (sync_run),
        .state   (fsm_state),
        .run_en  (run_en)
    );

    csc_gate u_gate (
        .clk       (clk_src),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .clk_out   (clk_out),
        .clk_out_b (clk_out_b),
        .out_en    (clk_out_b_oe)
    );

endmodule

// File: rtl/csc_chk.sv
module csc_chk
    import csc_pkg::*;
(
    input logic       clk_src,
    input logic       rst_n,
    input logic       clk_out,
    input logic       clk_out_b,
    input logic       clk_out_b_oe,
    input csc_state_e state,
    input logic       sync_run
);

    // Sampled at the falling edge: the values seen are those of the high phase just ending.
    assert_parked_low_R3: assert property (@(negedge clk_src) disable iff (!rst_n)
        !clk_out_b_oe |-> !clk_out);

    assert_enabled_pulses_R3: assert property (@(negedge clk_src) disable iff (!rst_n)
        clk_out_b_oe |-> clk_out);

    assert_complement_R4: assert property (@(negedge clk_src) disable iff (!rst_n)
        clk_out_b_oe |-> (clk_out_b == !clk_out));

    assert_stop_taken_R2: assert property (@(posedge clk_src) disable iff (!rst_n)
        (state == ST_RUN && !sync_run) |=> (state != ST_RUN));

    assert_restart_taken_R5: assert property (@(posedge clk_src) disable iff (!rst_n)
        (state == ST_PARKED && sync_run) |=> (state != ST_PARKED));

    assert_drain_completes_R6: assert property (@(posedge clk_src) disable iff (!rst_n)
        (state == ST_DRAIN) |=> (state == ST_DRAIN || state == ST_PARKED));

endmodule

bind clk_stop_ctrl csc_chk u_chk (
    .clk_src      (clk_src),
    .rst_n        (rst_n),
    .clk_out      (clk_out),
    .clk_out_b    (clk_out_b),
    .clk_out_b_oe (clk_out_b_oe),
    .state        (fsm_state),
    .sync_run     (sync_run)
);

// File: tb/tb_clk_stop_ctrl.sv
module tb_clk_stop_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DC1 = 1;
    localparam int WC1 = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_n = 1'b1;
    logic c  [2];
    logic cb [2];
    logic oe [2];

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";

    // Model state.
    int dcv [2] = '{0, DC1};
    int wcv [2] = '{0, WC1};
    int mode [2];   // 0 run, 1 drain, 2 parked, 3 wake
    int cnt  [2];
    bit hist [$];
    int pc   [2];   // pulses seen since mark
    int miss [2];   // missing pulses since mark
    int first_at [2];
    int step_no;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_stop_ctrl dut (
        .clk_src(clk), .rst_n(rst_n), .stop_req_n(req_n),
        .clk_out(c[0]), .clk_out_b(cb[0]), .clk_out_b_oe(oe[0])
    );

    clk_stop_ctrl #(.SYNC_STAGES(2), .DRAIN_CYC(DC1), .WAKE_CYC(WC1)) dut_slow (
        .clk_src(clk), .rst_n(rst_n), .stop_req_n(req_n),
        .clk_out(c[1]), .clk_out_b(cb[1]), .clk_out_b_oe(oe[1])
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d (t=%0t)", tag, what, got, exp, $time);
        end
    endtask

    function automatic bit m_run(input int i);
        return (mode[i] == 0 || mode[i] == 1);
    endfunction

    task automatic m_edge(input bit lvl);
        hist.push_back(lvl);
        begin
            bit use_lvl = hist.pop_front();
            for (int i = 0; i < 2; i++) begin
                case (mode[i])
                    0: if (!use_lvl) begin
                           if (dcv[i] > 0) begin mode[i] = 1; cnt[i] = dcv[i]; end
                           else mode[i] = 2;
                       end
                    1: begin cnt[i]--; if (cnt[i] == 0) mode[i] = 2; end
                    2: if (use_lvl) begin
                           if (wcv[i] > 0) begin mode[i] = 3; cnt[i] = wcv[i]; end
                           else mode[i] = 0;
                       end
                    default: begin cnt[i]--; if (cnt[i] == 0) mode[i] = 0; end
                endcase
            end
        end
    endtask

    task automatic model_reset();
        hist.delete();
        hist.push_back(1'b1);
        hist.push_back(1'b1);
        for (int i = 0; i < 2; i++) begin mode[i] = 0; cnt[i] = 0; end
    endtask

    task automatic mark();
        for (int i = 0; i < 2; i++) begin pc[i] = 0; miss[i] = 0; first_at[i] = -1; end
        step_no = 0;
    endtask

    // One source cycle: sample, compare, advance the model, then drive the next level.
    task automatic step(input bit nxt, input bit glitch);
        logic a [2];
        @(posedge clk);
        #(CLK_PERIOD/10);
        for (int i = 0; i < 2; i++) a[i] = c[i];
        #(CLK_PERIOD/5);
        for (int i = 0; i < 2; i++) begin
            chk(cur_tag, $sformatf("inst%0d pulse", i), int'(c[i]), int'(m_run(i)));
            chk("R3", $sformatf("inst%0d whole high phase", i), int'(a[i]), int'(c[i]));
            chk("R4", $sformatf("inst%0d oe in high phase", i), int'(oe[i]), int'(m_run(i)));
            if (oe[i]) chk("R4", $sformatf("inst%0d complement high", i), int'(cb[i]), 0);
            if (c[i]) begin
                pc[i]++;
                if (first_at[i] < 0) first_at[i] = step_no;
            end else miss[i]++;
        end
        m_edge(req_n);
        step_no++;
        #(CLK_PERIOD*2/5);
        for (int i = 0; i < 2; i++) begin
            chk("R3", $sformatf("inst%0d low phase", i), int'(c[i]), 0);
            chk("R4", $sformatf("inst%0d oe in low phase", i), int'(oe[i]), int'(m_run(i)));
            if (oe[i]) chk("R4", $sformatf("inst%0d complement low", i), int'(cb[i]), 1);
        end
        #(CLK_PERIOD/10);
        if (glitch) begin
            req_n = ~nxt;
            #(CLK_PERIOD/10);
        end
        req_n = nxt;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        model_reset();
        repeat (2) @(posedge clk);
        #(CLK_PERIOD/5);
        // R1: reset state, clock passes while reset is low
        chk("R1", "clk_out in reset high phase", int'(c[0]), 1);
        chk("R1", "oe in reset", int'(oe[0]), 1);
        chk("R1", "oe in reset slow", int'(oe[1]), 1);
        @(posedge clk);
        #(CLK_PERIOD*4/5);
        rst_n = 1'b1;

        cur_tag = "R1";
        mark();
        for (int n = 0; n < 6; n++) step(1'b1, 1'b0);
        chk("R1", "pulses after reset", pc[0], 6);

        // R2 / R8: hold stop low
        cur_tag = "R2";
        step(1'b0, 1'b0);
        mark();
        for (int n = 0; n < 10; n++) step(1'b0, 1'b0);
        chk("R2", "stop pulse count default", pc[0], 3);
        chk("R8", "stop pulse count with drain", pc[1], 3 + DC1);

        // R5 / R8: release
        cur_tag = "R5";
        step(1'b1, 1'b0);
        mark();
        for (int n = 0; n < 10; n++) step(1'b1, 1'b0);
        chk("R5", "idle cycles before first pulse default", first_at[0], 3);
        chk("R8", "idle cycles before first pulse with wake", first_at[1], 3 + WC1);

        // R6: one-edge request still gives a full sequence
        cur_tag = "R6";
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        mark();
        for (int n = 0; n < 12; n++) step(1'b1, 1'b0);
        chk("R6", "missing pulses default", miss[0], 1);
        chk("R6", "missing pulses with wake", miss[1], 1 + WC1);

        // R7: low pulse between edges is ignored
        cur_tag = "R7";
        step(1'b1, 1'b1);
        mark();
        for (int n = 0; n < 8; n++) step(1'b1, 1'b0);
        chk("R7", "missing pulses after unsampled glitch", miss[0], 0);
        chk("R7", "missing pulses after unsampled glitch slow", miss[1], 0);

        // R6: assorted request patterns, compared cycle by cycle
        cur_tag = "R6";
        for (int n = 0; n < 60; n++) step(((n * 7) % 5) > 1, 1'b0);
        for (int n = 0; n < 12; n++) step(1'b1, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule